// File: doc/BRIEF.md
# Control Register Side-Effect Unit

This unit sits beside a processor's control register file. It works out what a register write does beyond storing its data. For each accepted write it produces four things: the value to store, the next long-mode-active flag, and full or non-global flush pulses for both the instruction and data TLBs. It also raises a strobe one cycle later that tells the mode logic to recompute. The enclosing register file keeps CR0, CR4, the extended-feature enable bits and the code-segment attributes, and feeds their present values back in.

The unit owns three pieces of state: the stored base and the effective base of eight segments, a free-running cycle counter, and a time-stamp offset. The effective bases follow the stored bases, but four of them are forced to zero while the processor runs 64-bit code. The unit zeroes or restores those four when the code-segment long bit flips. The time stamp is kept as an offset from the cycle counter, so it advances without being written every cycle.

Register select encoding (5 bits):
- 0 = CR0
- 1 = CR3
- 2 = CR4
- 3 = code-segment attributes
- 4 = stack-segment attributes
- 5 = time stamp
- 8+i = base of segment i, where i = 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS, 6 TR, 7 IDTR

Any other select is stored unchanged and has no side effect.

Top module: `crw_side_effects`

## Requirements
- R1: On a CR0 write (select 0) where bit 31 (paging) differs from `cur_cr0` bit 31 and `cur_efer_lme` is 1, `lma_next` equals the written bit 31. In every other cycle `lma_next` equals `cur_efer_lma`.
- R2: A CR0 write whose bit 31 differs from `cur_cr0` bit 31 raises both full-flush outputs in the same cycle. This happens whatever `cur_efer_lme` is.
- R3: For a CR0 write, `store_val` is the written data with bit 4 set to 1. For every other select, `store_val` equals `wr_data`.
- R4: Every CR3 write (select 1) raises both non-global flush outputs in the same cycle, and neither full-flush output.
- R5: A CR4 write (select 2) raises both full-flush outputs only when bit 4, bit 5 or bit 7 differs from `cur_cr4`. Toggles of any other CR4 bit cause no flush.
- R6: A code-segment attribute write (select 3) whose bit 5 (long) differs from `cur_cs_long` changes effective bases 0 to 3 from the next cycle on. A new value of 1 sets them to zero. A new value of 0 sets them to their stored bases. A write that leaves the long bit unchanged alters no effective base.
- R7: A write to the base of segment 4 to 7 updates that segment's effective base to the written value from the next cycle, in every mode.
- R8: A write to the base of segment 0 to 3 always updates the stored base. It updates the effective base only when `cur_efer_lma` or `cur_cs_long` is 0.
- R9: A time-stamp write (select 5) of value V makes `tsc_val` read V+1 in the next cycle. With no write, `tsc_val` rises by exactly 1 each cycle.
- R10: `mode_stb` is 1 for one cycle exactly one cycle after a write with select 0, 3 or 4, and is 0 otherwise.
- R11: All flush outputs are 0 when `wr_valid` is 0. The instruction and data flush outputs of each kind are always equal.
- R12: After reset, `mode_stb` is 0, all effective bases are zero and `tsc_val` starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A register write is accepted this cycle |
| wr_sel | input | 5 | Register select, encoded as listed above |
| wr_data | input | XLEN | Data being written |
| cur_cr0 | input | XLEN | Present CR0 value |
| cur_cr4 | input | XLEN | Present CR4 value |
| cur_efer_lme | input | 1 | Long mode enable bit |
| cur_efer_lma | input | 1 | Present long-mode-active flag |
| cur_cs_long | input | 1 | Present code-segment long bit |
| store_val | output | XLEN | Value the register file stores |
| lma_next | output | 1 | Next long-mode-active flag |
| itlb_flush_all | output | 1 | Full flush pulse, instruction TLB |
| dtlb_flush_all | output | 1 | Full flush pulse, data TLB |
| itlb_flush_ng | output | 1 | Non-global flush pulse, instruction TLB |
| dtlb_flush_ng | output | 1 | Non-global flush pulse, data TLB |
| eff_base | output | NSEG*XLEN | Effective base of each segment, segment i in slice i |
| tsc_val | output | XLEN | Time-stamp read value |
| mode_stb | output | 1 | Mode recompute strobe |

## Verification
The checker watches several behaviours on every cycle:
- the long-mode flag holds its value outside CR0 writes;
- the ET bit is forced on CR0 writes;
- CR3 writes always raise the non-global flush;
- each flush pulse appears only alongside a write, with the instruction and data pulses always equal;
- the time stamp steps by one when no write occurs;
- the mode strobe follows exactly the writes that should cause it.

Some behaviours only the bench scenarios can show:
- which bit toggles cause a flush and which do not;
- the zeroing and later restoring of the four gated effective bases across a long-bit round trip;
- base writes being suppressed in 64-bit mode while the stored copy is kept;
- the exact time-stamp value after a write.

// File: rtl/crw_pkg.sv
package crw_pkg;
    localparam int SEL_W = 5;

    localparam logic [SEL_W-1:0] SEL_CR0    = 5'd0;
    localparam logic [SEL_W-1:0] SEL_CR3    = 5'd1;
    localparam logic [SEL_W-1:0] SEL_CR4    = 5'd2;
    localparam logic [SEL_W-1:0] SEL_CSATTR = 5'd3;
    localparam logic [SEL_W-1:0] SEL_SSATTR = 5'd4;
    localparam logic [SEL_W-1:0] SEL_TSC    = 5'd5;
    localparam logic [SEL_W-1:0] SEL_SEG0   = 5'd8;

    localparam int NSEG   = 8;   // segment base slots starting at SEL_SEG0
    localparam int NGATED = 4;   // first slots are ignored in 64-bit mode

    localparam int CR0_PG_BIT   = 31;
    localparam int CR0_ET_BIT   = 4;
    localparam int CR4_PSE_BIT  = 4;
    localparam int CR4_PAE_BIT  = 5;
    localparam int CR4_PGE_BIT  = 7;
    localparam int CSA_LONG_BIT = 5;
endpackage

// File: rtl/crw_cr_eval.sv
module crw_cr_eval
    import crw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             wr_valid,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [XLEN-1:0]  cur_cr0,
    input  logic [XLEN-1:0]  cur_cr4,
    input  logic             efer_lme,
    input  logic             efer_lma,
    output logic [XLEN-1:0]  store_val,
    output logic             lma_next,
    output logic             flush_all,
    output logic             flush_ng
);
    localparam logic [XLEN-1:0] PG_MASK = XLEN'(1) << CR0_PG_BIT;
    localparam logic [XLEN-1:0] ET_MASK = XLEN'(1) << CR0_ET_BIT;
    localparam logic [XLEN-1:0] CR4_FLUSH_MASK = (XLEN'(1) << CR4_PSE_BIT)
                                               | (XLEN'(1) << CR4_PAE_BIT)
                                               | (XLEN'(1) << CR4_PGE_BIT);

    logic cr0_wr, cr3_wr, cr4_wr;
    logic pg_flip, pg_new, cr4_flip;

    always_comb begin
        cr0_wr   = wr_valid && (wr_sel == SEL_CR0);
        cr3_wr   = wr_valid && (wr_sel == SEL_CR3);
        cr4_wr   = wr_valid && (wr_sel == SEL_CR4);
        pg_flip  = ((cur_cr0 ^ wr_data) & PG_MASK) != '0;
        pg_new   = (wr_data & PG_MASK) != '0;
        cr4_flip = ((cur_cr4 ^ wr_data) & CR4_FLUSH_MASK) != '0;

        store_val = cr0_wr ? (wr_data | ET_MASK) : wr_data;
        lma_next  = (cr0_wr && pg_flip && efer_lme) ? pg_new : efer_lma;
        flush_all = (cr0_wr && pg_flip) || (cr4_wr && cr4_flip);
        flush_ng  = cr3_wr;
    end
endmodule

// File: rtl/crw_seg_bases.sv
module crw_seg_bases
    import crw_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int SEG_COUNT = NSEG,
    parameter int GATED     = NGATED
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_valid,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [XLEN-1:0]                wr_data,
    input  logic                           efer_lma,
    input  logic                           cs_long,
    output logic [SEG_COUNT-1:0][XLEN-1:0] eff_base
);
    typedef struct packed {
        logic [SEG_COUNT-1:0][XLEN-1:0] base;
        logic [SEG_COUNT-1:0][XLEN-1:0] eff;
    } seg_st_t;

    seg_st_t st_d, st_q;
    logic    in_64bit, long_new, long_flip;

    always_comb begin
        st_d      = st_q;
        in_64bit  = efer_lma && cs_long;
        long_new  = wr_data[CSA_LONG_BIT];
        long_flip = wr_valid && (wr_sel == SEL_CSATTR) && (long_new != cs_long);

        if (long_flip) begin
            for (int i = 0; i < GATED; i++) begin
                st_d.eff[i] = long_new ? '0 : st_q.base[i];
            end
        end

        for (int i = 0; i < SEG_COUNT; i++) begin
            if (wr_valid && (wr_sel == SEL_SEG0 + SEL_W'(i))) begin
                st_d.base[i] = wr_data;
                if ((i >= GATED) || !in_64bit) begin
                    st_d.eff[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign eff_base = st_q.eff;
endmodule

// File: rtl/crw_tsc.sv
module crw_tsc
    import crw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  tsc_val
);
    typedef struct packed {
        logic [XLEN-1:0] cyc;
        logic [XLEN-1:0] off;
    } tsc_st_t;

    tsc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + XLEN'(1);
        if (wr_valid && (wr_sel == SEL_TSC)) begin
            st_d.off = wr_data - st_q.cyc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tsc_val = st_q.off + st_q.cyc;
endmodule

// File: rtl/crw_side_effects.sv
module crw_side_effects
    import crw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [XLEN-1:0]           wr_data,
    input  logic [XLEN-1:0]           cur_cr0,
    input  logic [XLEN-1:0]           cur_cr4,
    input  logic                      cur_efer_lme,
    input  logic                      cur_efer_lma,
    input  logic                      cur_cs_long,
    output logic [XLEN-1:0]           store_val,
    output logic                      lma_next,
    output logic                      itlb_flush_all,
    output logic                      dtlb_flush_all,
    output logic                      itlb_flush_ng,
    output logic                      dtlb_flush_ng,
    output logic [NSEG-1:0][XLEN-1:0] eff_base,
    output logic [XLEN-1:0]           tsc_val,
    output logic                      mode_stb
);
    typedef struct packed {
        logic mode_stb;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    flush_all, flush_ng;

    crw_cr_eval #(.XLEN(XLEN)) u_cr (
        .wr_valid  (wr_valid),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cur_cr0   (cur_cr0),
        .cur_cr4   (cur_cr4),
        .efer_lme  (cur_efer_lme),
        .efer_lma  (cur_efer_lma),
        .store_val (store_val),
        .lma_next  (lma_next),
        .flush_all (flush_all),
        .flush_ng  (flush_ng)
    );

    crw_seg_bases #(.XLEN(XLEN), .SEG_COUNT(NSEG), .GATED(NGATED)) u_seg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .efer_lma (cur_efer_lma),
        .cs_long  (cur_cs_long),
        .eff_base (eff_base)
    );

    crw_tsc #(.XLEN(XLEN)) u_tsc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tsc_val  (tsc_val)
    );

    assign itlb_flush_all = flush_all;
    assign dtlb_flush_all = flush_all;
    assign itlb_flush_ng  = flush_ng;
    assign dtlb_flush_ng  = flush_ng;

    always_comb begin
        st_d.mode_stb = wr_valid && ((wr_sel == SEL_CR0) || (wr_sel == SEL_CSATTR)
                                  || (wr_sel == SEL_SSATTR));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_stb = st_q.mode_stb;
endmodule

// File: rtl/crw_side_effects_chk.sv
module crw_side_effects_chk
    import crw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [SEL_W-1:0] wr_sel,
    input logic             cur_efer_lma,
    input logic [XLEN-1:0]  store_val,
    input logic             lma_next,
    input logic             itlb_flush_all,
    input logic             dtlb_flush_all,
    input logic             itlb_flush_ng,
    input logic             dtlb_flush_ng,
    input logic [XLEN-1:0]  tsc_val,
    input logic             mode_stb
);
    localparam logic [XLEN-1:0] ET_MASK = XLEN'(1) << CR0_ET_BIT;

    logic up_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) up_q <= 1'b0;
        else        up_q <= 1'b1;
    end

    logic cr0_w, tsc_w, mode_w;
    assign cr0_w  = wr_valid && (wr_sel == SEL_CR0);
    assign tsc_w  = wr_valid && (wr_sel == SEL_TSC);
    assign mode_w = wr_valid && ((wr_sel == SEL_CR0) || (wr_sel == SEL_CSATTR)
                              || (wr_sel == SEL_SSATTR));

    p_lma_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_w |-> (lma_next == cur_efer_lma));

    p_et_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_w |-> ((store_val & ET_MASK) != '0));

    p_ng_on_cr3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_sel == SEL_CR3)) |-> (itlb_flush_ng && dtlb_flush_ng && !itlb_flush_all));

    p_flush_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_flush_all == dtlb_flush_all) && (itlb_flush_ng == dtlb_flush_ng));

    p_flush_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (itlb_flush_all || itlb_flush_ng) |-> wr_valid);

    p_tsc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !$past(tsc_w)) |-> (tsc_val == $past(tsc_val) + XLEN'(1)));

    p_mode_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_w |=> mode_stb);

    p_mode_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && mode_stb) |-> $past(mode_w));
endmodule

bind crw_side_effects crw_side_effects_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_valid       (wr_valid),
    .wr_sel         (wr_sel),
    .cur_efer_lma   (cur_efer_lma),
    .store_val      (store_val),
    .lma_next       (lma_next),
    .itlb_flush_all (itlb_flush_all),
    .dtlb_flush_all (dtlb_flush_all),
    .itlb_flush_ng  (itlb_flush_ng),
    .dtlb_flush_ng  (dtlb_flush_ng),
    .tsc_val        (tsc_val),
    .mode_stb       (mode_stb)
);

// File: tb/crw_side_effects_test.sv
module crw_side_effects_test;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [4:0] wr_sel = '0;
    logic [XLEN-1:0] wr_data = '0, cur_cr0 = '0, cur_cr4 = '0;
    logic cur_efer_lme = 1'b0, cur_efer_lma = 1'b0, cur_cs_long = 1'b0;
    logic [XLEN-1:0] store_val, tsc_val;
    logic lma_next, itlb_flush_all, dtlb_flush_all, itlb_flush_ng, dtlb_flush_ng, mode_stb;
    logic [7:0][XLEN-1:0] eff_base;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crw_side_effects #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .cur_cr0(cur_cr0), .cur_cr4(cur_cr4), .cur_efer_lme(cur_efer_lme),
        .cur_efer_lma(cur_efer_lma), .cur_cs_long(cur_cs_long), .store_val(store_val),
        .lma_next(lma_next), .itlb_flush_all(itlb_flush_all), .dtlb_flush_all(dtlb_flush_all),
        .itlb_flush_ng(itlb_flush_ng), .dtlb_flush_ng(dtlb_flush_ng), .eff_base(eff_base),
        .tsc_val(tsc_val), .mode_stb(mode_stb)
    );

    typedef struct packed {
        logic [4:0]  sel;
        logic [31:0] data;
        logic [31:0] cr0;
        logic [31:0] cr4;
        logic        lme;
        logic        lma;
        logic [31:0] exp_store;
        logic        exp_lma;
        logic        exp_fa;
        logic        exp_ng;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0, 32'h8000_0001, 32'h0000_0011, 32'h0, 1'b1, 1'b0, 32'h8000_0011, 1'b1, 1'b1, 1'b0},
        '{5'd0, 32'h0000_0011, 32'h8000_0011, 32'h0, 1'b1, 1'b1, 32'h0000_0011, 1'b0, 1'b1, 1'b0},
        '{5'd0, 32'h8000_0001, 32'h0000_0001, 32'h0, 1'b0, 1'b0, 32'h8000_0011, 1'b0, 1'b1, 1'b0},
        '{5'd0, 32'h8000_0000, 32'h8000_0011, 32'h0, 1'b1, 1'b1, 32'h8000_0010, 1'b1, 1'b0, 1'b0},
        '{5'd1, 32'h0123_4000, 32'h0,         32'h0, 1'b0, 1'b0, 32'h0123_4000, 1'b0, 1'b0, 1'b1},
        '{5'd2, 32'h0000_0020, 32'h0, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0020, 1'b0, 1'b1, 1'b0},
        '{5'd2, 32'h0000_0090, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 32'h0000_0090, 1'b0, 1'b1, 1'b0},
        '{5'd2, 32'h0000_001B, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 32'h0000_001B, 1'b0, 1'b0, 1'b0},
        '{5'd2, 32'h0000_0000, 32'h0, 32'h0000_0010, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0},
        '{5'd4, 32'h0000_FFFF, 32'h0, 32'h0,         1'b0, 1'b1, 32'h0000_FFFF, 1'b1, 1'b0, 1'b0},
        '{5'd0, 32'h0000_0000, 32'h8000_0000, 32'h0, 1'b0, 1'b1, 32'h0000_0010, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] sel, input logic [XLEN-1:0] data);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_sel   = sel;
        wr_data  = data;
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] t0;

        // R12: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(mode_stb == 1'b0, "R12 mode_stb in reset", XLEN'(mode_stb), 0);
        chk(eff_base == '0, "R12 eff_base in reset", eff_base[0], 0);
        chk(tsc_val == '0, "R12 tsc in reset", tsc_val, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: a CR3 select without valid flushes nothing
        wr_sel = 5'd1;
        #1;
        chk(!itlb_flush_ng && !dtlb_flush_ng && !itlb_flush_all, "R11 no flush without valid",
            XLEN'({itlb_flush_ng, itlb_flush_all}), 0);

        // R1 R2 R3 R4 R5 R11: table of combinational write cases
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            wr_valid     = 1'b1;
            wr_sel       = VECS[k].sel;
            wr_data      = XLEN'(VECS[k].data);
            cur_cr0      = XLEN'(VECS[k].cr0);
            cur_cr4      = XLEN'(VECS[k].cr4);
            cur_efer_lme = VECS[k].lme;
            cur_efer_lma = VECS[k].lma;
            #1;
            chk(store_val == XLEN'(VECS[k].exp_store), "R3 store value", store_val,
                XLEN'(VECS[k].exp_store));
            chk(lma_next == VECS[k].exp_lma, "R1 lma_next", XLEN'(lma_next),
                XLEN'(VECS[k].exp_lma));
            chk(itlb_flush_all == VECS[k].exp_fa && dtlb_flush_all == VECS[k].exp_fa,
                "R2/R5 full flush", XLEN'({itlb_flush_all, dtlb_flush_all}),
                XLEN'({VECS[k].exp_fa, VECS[k].exp_fa}));
            chk(itlb_flush_ng == VECS[k].exp_ng && dtlb_flush_ng == VECS[k].exp_ng,
                "R4 non-global flush", XLEN'({itlb_flush_ng, dtlb_flush_ng}),
                XLEN'({VECS[k].exp_ng, VECS[k].exp_ng}));
        end
        @(negedge clk);
        wr_valid = 1'b0;
        cur_efer_lma = 1'b0;
        cur_efer_lme = 1'b0;
        cur_cr0 = '0;
        cur_cr4 = '0;

        // R8: gated base writes outside 64-bit mode
        cur_cs_long = 1'b0;
        wr(5'd8, 64'hAAAA);
        chk(eff_base[0] == 64'hAAAA, "R8 ES base outside 64-bit", eff_base[0], 64'hAAAA);
        wr(5'd11, 64'hDDDD);
        chk(eff_base[3] == 64'hDDDD, "R8 DS base outside 64-bit", eff_base[3], 64'hDDDD);

        // R6: attribute write with long bit unchanged leaves bases alone
        cur_efer_lma = 1'b1;
        cur_cs_long = 1'b1;
        wr(5'd3, 64'h20);
        chk(eff_base[0] == 64'hAAAA, "R6 no toggle keeps ES", eff_base[0], 64'hAAAA);

        // R6: long bit 0 -> 1 zeroes the gated effective bases
        cur_cs_long = 1'b0;
        wr(5'd3, 64'h20);
        chk(eff_base[0] == '0, "R6 enter long zeroes ES", eff_base[0], 0);
        chk(eff_base[3] == '0, "R6 enter long zeroes DS", eff_base[3], 0);

        // R7: ungated base write in 64-bit mode
        cur_cs_long = 1'b1;
        wr(5'd12, 64'hF0F0);
        chk(eff_base[4] == 64'hF0F0, "R7 FS base in 64-bit", eff_base[4], 64'hF0F0);

        // R8: gated base write in 64-bit mode is held back
        wr(5'd8, 64'h5555);
        chk(eff_base[0] == '0, "R8 ES suppressed in 64-bit", eff_base[0], 0);

        // R6: long bit 1 -> 0 restores from stored bases
        wr(5'd3, 64'h0);
        chk(eff_base[0] == 64'h5555, "R6 leave long restores ES", eff_base[0], 64'h5555);
        chk(eff_base[3] == 64'hDDDD, "R6 leave long restores DS", eff_base[3], 64'hDDDD);
        chk(eff_base[4] == 64'hF0F0, "R6 leave long keeps FS", eff_base[4], 64'hF0F0);

        // R8: lma clear with long bit set still updates
        cur_efer_lma = 1'b0;
        wr(5'd9, 64'h9999);
        chk(eff_base[1] == 64'h9999, "R8 CS base with lma clear", eff_base[1], 64'h9999);

        // R10: mode strobe timing
        @(negedge clk);
        wr_valid = 1'b1;
        wr_sel = 5'd0;
        wr_data = 64'h11;
        cur_cr0 = 64'h11;
        #1;
        chk(mode_stb == 1'b0, "R10 strobe not in write cycle", XLEN'(mode_stb), 0);
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        chk(mode_stb == 1'b1, "R10 strobe one cycle after", XLEN'(mode_stb), 1);
        @(negedge clk);
        #1;
        chk(mode_stb == 1'b0, "R10 strobe single cycle", XLEN'(mode_stb), 0);
        wr(5'd1, 64'h1000);
        chk(mode_stb == 1'b0, "R10 no strobe after CR3", XLEN'(mode_stb), 0);

        // R9: time stamp
        @(negedge clk);
        #1;
        t0 = tsc_val;
        @(negedge clk);
        #1;
        chk(tsc_val == t0 + 1, "R9 tsc steps by one", tsc_val, t0 + 1);
        wr(5'd5, 64'd1000);
        chk(tsc_val == 64'd1001, "R9 tsc after write", tsc_val, 64'd1001);
        repeat (10) @(negedge clk);
        #1;
        chk(tsc_val == 64'd1011, "R9 tsc ten cycles later", tsc_val, 64'd1011);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule